// File: doc/BRIEF.md
# TFT Panel Timing Generator

This block produces the raster timing for a digital TFT panel from a pixel clock and a set of static configuration fields. A horizontal counter steps through each line in pixel clocks and a vertical counter steps through each frame in lines. From these two counts the block decodes an active-low line sync, an active-low frame sync, a data-enable strobe and a shift clock for the panel.

Horizontal total and display width are programmed in units of eight pixels. The frame sync does not start at column zero. It falls a programmed number of pixel clocks after the line sync falls on line 0, and it stays low for a programmed number of whole lines. The registered pixel column and line number are also driven out, so that a pixel fetch unit can supply data for the same position that the strobes describe.

The configuration inputs are treated as static. The frame sync phase must be smaller than the horizontal total, and the display windows must lie inside the totals.

Top module: `tft_tgen`

## Requirements
- R1: While reset is asserted (active-low `rst_n`, asynchronous) and on the first sample after it is released, `frame_n` and `line_n` are 1, `de` is 0, `pix_x` and `line_y` are 0, and `shift_clk` is 0 during reset.
- R2: `pix_x` counts 0, 1, … up to (`cfg_htot`+1)×8−1 on successive pixel clocks and then returns to 0.
- R3: `line_y` increments on the clock where `pix_x` wraps. After value `cfg_vtot` it returns to 0, so a frame has `cfg_vtot`+1 lines.
- R4: `line_n` is 0 exactly when `pix_x` ≤ `cfg_hsync_w`, so the line sync is low for `cfg_hsync_w`+1 pixel clocks at the start of every line.
- R5: Let p = `cfg_vphase`+1 and q = `line_y`×htotal+`pix_x`. `frame_n` is 0 exactly when p ≤ q < p+(`cfg_vsync_w`+1)×htotal. The frame sync therefore falls p clocks after the line sync falls on line 0 and lasts `cfg_vsync_w`+1 lines.
- R6: Within a displayed line, `de` is 1 exactly for `cfg_hstart` ≤ `pix_x` < `cfg_hstart`+(`cfg_hdisp`+1)×8.
- R7: `de` is 1 only on lines `cfg_vstart` through `cfg_vstart`+`cfg_vdisp` inclusive, and it is 0 on every other line.
- R8: After reset the sequence starts at position (0,0). On the n-th clock edge after release, the outputs describe linear frame position n−1, and all outputs refer to that same pixel.
- R9: Once reset is released, `shift_clk` is high while the pixel clock is high and low while it is low. It therefore has one pixel-clock period, 50% duty, and falls half a period after the outputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_vtot | input | 10 | Lines per frame minus one |
| cfg_vsync_w | input | 3 | Frame sync width in lines minus one |
| cfg_vphase | input | 10 | Frame sync delay after line sync, minus one |
| cfg_htot | input | 7 | Horizontal total in 8-pixel units minus one |
| cfg_hsync_w | input | 7 | Line sync width in pixel clocks minus one |
| cfg_hdisp | input | 7 | Display width in 8-pixel units minus one |
| cfg_hstart | input | 10 | First displayed column |
| cfg_vstart | input | 10 | First displayed line |
| cfg_vdisp | input | 10 | Displayed lines minus one |
| frame_n | output | 1 | Frame sync, active low |
| line_n | output | 1 | Line sync, active low |
| de | output | 1 | Data enable |
| shift_clk | output | 1 | Panel shift clock |
| pix_x | output | 10 | Current pixel column |
| line_y | output | 10 | Current line |

## Verification
The hardest case to reach is the frame sync crossing line boundaries. Its start and end fall mid-line, at the same phase on two different lines. This happens only once per frame and depends on how the phase relates to the horizontal total. The stimulus uses small configurations so that full frames are short. It sweeps every pixel of two or more complete frames in each configuration. One configuration puts the phase one column before the wrap, one uses a one-line pulse, and one places the display window on the first or the last line of the frame. For every position the bench computes the expected value of each output from the linear position.

// File: rtl/tft_tgen_pkg.sv
package tft_tgen_pkg;

    localparam int VT_W  = 10;
    localparam int VPW_W = 3;
    localparam int PH_W  = 10;
    localparam int HT_W  = 7;
    localparam int HPW_W = 7;
    localparam int HDP_W = 7;
    localparam int HDS_W = 10;
    localparam int VD_W  = 10;
    localparam int HC_W  = HT_W + 3;
    localparam int CW    = HC_W + 2;
    localparam int VW    = VT_W + 1;

    typedef struct packed {
        logic            run;
        logic            frame_n;
        logic            line_n;
        logic            de;
        logic [HC_W-1:0] x;
        logic [VT_W-1:0] y;
    } sync_t;

endpackage

// File: rtl/tft_tgen_hcount.sv
module tft_tgen_hcount
    import tft_tgen_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [HT_W-1:0] cfg_htot,
    output logic [HC_W-1:0] h_cnt,
    output logic            h_wrap
);

    typedef struct packed {
        logic [HC_W-1:0] h;
    } hstate_t;

    hstate_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        h_wrap = (st_q.h == {cfg_htot, 3'b111});
        if (h_wrap) st_d.h = '0;
        else        st_d.h = st_q.h + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign h_cnt = st_q.h;

endmodule

// File: rtl/tft_tgen_vcount.sv
module tft_tgen_vcount
    import tft_tgen_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    input  logic [VT_W-1:0] cfg_vtot,
    output logic [VT_W-1:0] v_cnt
);

    typedef struct packed {
        logic [VT_W-1:0] v;
    } vstate_t;

    vstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            if (st_q.v == cfg_vtot) st_d.v = '0;
            else                    st_d.v = st_q.v + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign v_cnt = st_q.v;

endmodule

// File: rtl/tft_tgen_syncgen.sv
module tft_tgen_syncgen
    import tft_tgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [HC_W-1:0]  h_cnt,
    input  logic [VT_W-1:0]  v_cnt,
    input  logic [VPW_W-1:0] cfg_vsync_w,
    input  logic [PH_W-1:0]  cfg_vphase,
    input  logic [HPW_W-1:0] cfg_hsync_w,
    input  logic [HDP_W-1:0] cfg_hdisp,
    input  logic [HDS_W-1:0] cfg_hstart,
    input  logic [VT_W-1:0]  cfg_vstart,
    input  logic [VD_W-1:0]  cfg_vdisp,
    output sync_t            sync_q
);

    sync_t          sync_d;
    logic [CW-1:0]  hx, phase, hde_lo, hde_hi;
    logic [VW-1:0]  vx, vpw, vde_lo, vde_hi;
    logic           in_h, in_v;

    always_comb begin
        hx     = CW'(h_cnt);
        vx     = VW'(v_cnt);
        phase  = CW'(cfg_vphase) + CW'(1);
        vpw    = VW'(cfg_vsync_w) + VW'(1);
        hde_lo = CW'(cfg_hstart);
        hde_hi = CW'(cfg_hstart) + CW'({cfg_hdisp, 3'b000}) + CW'(8);
        vde_lo = VW'(cfg_vstart);
        vde_hi = VW'(cfg_vstart) + VW'(cfg_vdisp);
        in_h   = (hx >= hde_lo) && (hx < hde_hi);
        in_v   = (vx >= vde_lo) && (vx <= vde_hi);

        sync_d         = sync_q;
        sync_d.run     = 1'b1;
        sync_d.x       = h_cnt;
        sync_d.y       = v_cnt;
        sync_d.line_n  = !(hx <= CW'(cfg_hsync_w));
        sync_d.frame_n = !(((vx == '0) && (hx >= phase)) ||
                           ((vx != '0) && (vx < vpw)) ||
                           ((vx == vpw) && (hx < phase)));
        sync_d.de      = in_h && in_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q         <= '0;
            sync_q.frame_n <= 1'b1;
            sync_q.line_n  <= 1'b1;
        end else begin
            sync_q <= sync_d;
        end
    end

endmodule

// File: rtl/tft_tgen.sv
module tft_tgen
    import tft_tgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VT_W-1:0]  cfg_vtot,
    input  logic [VPW_W-1:0] cfg_vsync_w,
    input  logic [PH_W-1:0]  cfg_vphase,
    input  logic [HT_W-1:0]  cfg_htot,
    input  logic [HPW_W-1:0] cfg_hsync_w,
    input  logic [HDP_W-1:0] cfg_hdisp,
    input  logic [HDS_W-1:0] cfg_hstart,
    input  logic [VT_W-1:0]  cfg_vstart,
    input  logic [VD_W-1:0]  cfg_vdisp,
    output logic             frame_n,
    output logic             line_n,
    output logic             de,
    output logic             shift_clk,
    output logic [HC_W-1:0]  pix_x,
    output logic [VT_W-1:0]  line_y
);

    logic [HC_W-1:0] h_cnt;
    logic [VT_W-1:0] v_cnt;
    logic            h_wrap;
    sync_t           sync_q;

    tft_tgen_hcount u_hcount (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_htot (cfg_htot),
        .h_cnt    (h_cnt),
        .h_wrap   (h_wrap)
    );

    tft_tgen_vcount u_vcount (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (h_wrap),
        .cfg_vtot (cfg_vtot),
        .v_cnt    (v_cnt)
    );

    tft_tgen_syncgen u_syncgen (
        .clk         (clk),
        .rst_n       (rst_n),
        .h_cnt       (h_cnt),
        .v_cnt       (v_cnt),
        .cfg_vsync_w (cfg_vsync_w),
        .cfg_vphase  (cfg_vphase),
        .cfg_hsync_w (cfg_hsync_w),
        .cfg_hdisp   (cfg_hdisp),
        .cfg_hstart  (cfg_hstart),
        .cfg_vstart  (cfg_vstart),
        .cfg_vdisp   (cfg_vdisp),
        .sync_q      (sync_q)
    );

    assign frame_n   = sync_q.frame_n;
    assign line_n    = sync_q.line_n;
    assign de        = sync_q.de;
    assign pix_x     = sync_q.x;
    assign line_y    = sync_q.y;
    assign shift_clk = clk & sync_q.run;

endmodule

// File: rtl/tft_tgen_chk.sv
module tft_tgen_chk
    import tft_tgen_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [VT_W-1:0]  cfg_vtot,
    input logic [VPW_W-1:0] cfg_vsync_w,
    input logic [PH_W-1:0]  cfg_vphase,
    input logic [HT_W-1:0]  cfg_htot,
    input logic [HPW_W-1:0] cfg_hsync_w,
    input logic [HDP_W-1:0] cfg_hdisp,
    input logic [HDS_W-1:0] cfg_hstart,
    input logic [VT_W-1:0]  cfg_vstart,
    input logic [VD_W-1:0]  cfg_vdisp,
    input logic             frame_n,
    input logic             line_n,
    input logic             de,
    input logic [HC_W-1:0]  pix_x,
    input logic [VT_W-1:0]  line_y
);

    logic [HC_W-1:0] last_x;
    logic [CW-1:0]   phase, de_end;
    logic [VW-1:0]   vde_end;

    assign last_x  = {cfg_htot, 3'b111};
    assign phase   = CW'(cfg_vphase) + CW'(1);
    assign de_end  = CW'(cfg_hstart) + CW'({cfg_hdisp, 3'b000}) + CW'(8);
    assign vde_end = VW'(cfg_vstart) + VW'(cfg_vdisp);

    a_r2_x_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_x == last_x) |=> (pix_x == '0));

    a_r3_y_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_x == last_x) && (line_y != cfg_vtot) |=> (line_y == $past(line_y) + 1'b1));

    a_r3_y_returns: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_x == last_x) && (line_y == cfg_vtot) |=> (line_y == '0));

    a_r4_line_low_span: assert property (@(posedge clk) disable iff (!rst_n)
        !line_n |-> (CW'(pix_x) <= CW'(cfg_hsync_w)));

    a_r5_frame_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_n && line_y == '0) |-> (CW'(pix_x) >= phase));

    a_r6_de_columns: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> ((CW'(pix_x) >= CW'(cfg_hstart)) && (CW'(pix_x) < de_end)));

    a_r7_de_lines: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> ((VW'(line_y) >= VW'(cfg_vstart)) && (VW'(line_y) <= vde_end)));

endmodule

bind tft_tgen tft_tgen_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_vtot    (cfg_vtot),
    .cfg_vsync_w (cfg_vsync_w),
    .cfg_vphase  (cfg_vphase),
    .cfg_htot    (cfg_htot),
    .cfg_hsync_w (cfg_hsync_w),
    .cfg_hdisp   (cfg_hdisp),
    .cfg_hstart  (cfg_hstart),
    .cfg_vstart  (cfg_vstart),
    .cfg_vdisp   (cfg_vdisp),
    .frame_n     (frame_n),
    .line_n      (line_n),
    .de          (de),
    .pix_x       (pix_x),
    .line_y      (line_y)
);

// File: tb/tft_tgen_tb.sv
module tft_tgen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] cfg_vtot = '0;
    logic [2:0] cfg_vsync_w = '0;
    logic [9:0] cfg_vphase = '0;
    logic [6:0] cfg_htot = '0;
    logic [6:0] cfg_hsync_w = '0;
    logic [6:0] cfg_hdisp = '0;
    logic [9:0] cfg_hstart = '0;
    logic [9:0] cfg_vstart = '0;
    logic [9:0] cfg_vdisp = '0;
    logic       frame_n, line_n, de, shift_clk;
    logic [9:0] pix_x, line_y;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tft_tgen dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_vtot(cfg_vtot), .cfg_vsync_w(cfg_vsync_w), .cfg_vphase(cfg_vphase),
        .cfg_htot(cfg_htot), .cfg_hsync_w(cfg_hsync_w), .cfg_hdisp(cfg_hdisp),
        .cfg_hstart(cfg_hstart), .cfg_vstart(cfg_vstart), .cfg_vdisp(cfg_vdisp),
        .frame_n(frame_n), .line_n(line_n), .de(de), .shift_clk(shift_clk),
        .pix_x(pix_x), .line_y(line_y)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run_cfg(input int vt, input int vpw, input int vph, input int ht,
                           input int hpw, input int hdp, input int hds,
                           input int vds, input int vdl, input int frames);
        int htot, vtot, ph, total;
        htot  = (ht + 1) * 8;
        vtot  = vt + 1;
        ph    = vph + 1;
        total = htot * vtot;
        @(negedge clk);
        rst_n       = 1'b0;
        cfg_vtot    = 10'(vt);
        cfg_vsync_w = 3'(vpw);
        cfg_vphase  = 10'(vph);
        cfg_htot    = 7'(ht);
        cfg_hsync_w = 7'(hpw);
        cfg_hdisp   = 7'(hdp);
        cfg_hstart  = 10'(hds);
        cfg_vstart  = 10'(vds);
        cfg_vdisp   = 10'(vdl);
        @(posedge clk);
        #1;
        chk("R1 shift_clk in reset", int'(shift_clk), 0);
        @(negedge clk);
        chk("R1 frame_n", int'(frame_n), 1);
        chk("R1 line_n", int'(line_n), 1);
        chk("R1 de", int'(de), 0);
        chk("R1 pix_x", int'(pix_x), 0);
        chk("R1 line_y", int'(line_y), 0);
        rst_n = 1'b1;
        for (int n = 1; n <= frames * total + 3; n++) begin
            int p, q, h, v, e_line, e_frame, e_de;
            @(posedge clk);
            #1;
            chk("R9 shift_clk high", int'(shift_clk), 1);
            @(negedge clk);
            #1;
            chk("R9 shift_clk low", int'(shift_clk), 0);
            p = n - 1;
            q = p % total;
            h = q % htot;
            v = q / htot;
            e_line  = (h <= hpw) ? 0 : 1;
            e_frame = (q >= ph && q < ph + (vpw + 1) * htot) ? 0 : 1;
            e_de    = (h >= hds && h < hds + (hdp + 1) * 8 &&
                       v >= vds && v <= vds + vdl) ? 1 : 0;
            chk("R2/R8 pix_x", int'(pix_x), h);
            chk("R3/R8 line_y", int'(line_y), v);
            chk("R4 line_n", int'(line_n), e_line);
            chk("R5 frame_n", int'(frame_n), e_frame);
            chk("R6/R7 de", int'(de), e_de);
        end
    endtask

    initial begin
        // R5 phase well inside line, two-line pulse; R7 window ends on the last line
        run_cfg(5, 1, 4, 1, 2, 0, 4, 3, 2, 2);
        // R5 phase one column before wrap, one-line pulse; R7 window on line 0 only
        run_cfg(3, 0, 22, 2, 0, 1, 3, 0, 0, 2);
        // R6 display reaching the last column; R4 long line pulse
        run_cfg(2, 2, 0, 0, 6, 0, 0, 1, 0, 2);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule